// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a single-supply flash array. It takes each completed bus write as a captured address and data word and matches the writes against multi-cycle unlock-style command sequences. Each recognised command becomes a one-cycle pulse to the program/erase controller: program (with its target address and data), chip erase, block-erase add (with the block address), suspend, resume and reset. The block also reports the mode it is in. In auto-select mode it returns the identification word picked by the two low read-address bits.

Bus writes cannot be held off, so the write port has a valid strobe and no ready signal. A write is taken on every clock edge where `wr_valid` is high, and the decoder never stalls. The controller reports its own state on plain level inputs. `ctl_lock` is high while a program or chip erase runs. `ctl_erase_run` is high while a block erase is pending or running. `ctl_add_open` is high while more blocks may still join the erase list. `ctl_error` is high while the error flag is set.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read) and no command pulse is high. Mode codes are: 0 read, 1 auto-select, 2 unlock bypass, 3 program pending, 4 erase setup, 5 erase suspended, 6 error.
- R2: The unlock prefix is data 0xAA at the first key address, then 0x55 at the second. When `byte_mode`=0 the keys are 0x555 and 0x2AA, and the command address is 0x555. When `byte_mode`=1 they are 0xAAA and 0x555, and the command address is 0xAAA. Only address bits 10..0 (11..0 in byte mode) and data bits 7..0 are compared.
- R3: Prefix, then 0xA0 at the command address, gives mode 3. The next write raises `prog_go` for one cycle, carrying that write's full address and data. The mode then returns to 0.
- R4: Prefix, then 0x90 at the command address, gives mode 1. In that mode `id_word` is `MFR_CODE` for `id_addr`=0, `DEV_CODE` for 1, `{15'b0,id_prot}` for 2, and 0 for 3. Outside mode 1, `id_word` is 0.
- R5: Prefix, then 0x80 at the command address, gives mode 4. A second prefix follows. Then 0x10 at the command address raises `chip_erase_go`, and 0x30 at any address raises `blk_add_go` with `blk_addr` set to that address. At most one command pulse is high in any cycle.
- R6: While `ctl_erase_run` and `ctl_add_open` are high and the decoder is not suspended, a write of 0x30 to any address raises `blk_add_go` with that address.
- R7: A write that breaks a sequence produces no pulse and returns the mode to 0. This also leaves auto-select.
- R8: A single write of 0xF0 to any address, or the prefix followed by 0xF0, raises `reset_go` and gives mode 0.
- R9: Prefix, then 0x20, gives mode 2. In that mode, 0xA0 followed by an address/data write raises `prog_go`, and 0x90 followed by 0x00 returns to mode 0. Every other write is ignored and the mode stays 2.
- R10: 0xB0 while `ctl_erase_run` is high raises `suspend_go` and gives mode 5. A program issued while suspended keeps mode 5. While suspended, 0xF0 raises no pulse. 0x30 raises `resume_go` and gives mode 0. Without `ctl_erase_run`, 0xB0 raises no pulse.
- R11: While `ctl_lock` is high, writes raise no pulse and leave the mode unchanged.
- R12: While `ctl_error` is high, `mode` is 6 and only a reset (single or prefixed) raises a pulse. A reset taken in bypass leaves mode 2 once the error clears.
- R13: While `ctl_erase_run` is high and the decoder is not suspended, writes other than 0xB0, 0xF0 and the 0x30 of R6 are ignored. An unlock prefix there leads to no program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = 8-bit bus (byte select in address bit 0) |
| wr_valid | input | 1 | A bus write is presented this cycle |
| wr_addr | input | ADDR_W | Captured write address |
| wr_data | input | DATA_W | Captured write data |
| ctl_lock | input | 1 | Controller busy with program or chip erase |
| ctl_erase_run | input | 1 | Block erase pending or running |
| ctl_add_open | input | 1 | Block list still accepts additions |
| ctl_error | input | 1 | Controller error flag |
| id_addr | input | 2 | Low read-address bits for identification |
| id_prot | input | 1 | Protection state of the addressed block |
| prog_go | output | 1 | Program command pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| chip_erase_go | output | 1 | Chip erase pulse |
| blk_add_go | output | 1 | Block-erase add pulse |
| blk_addr | output | ADDR_W | Block address for the add |
| suspend_go | output | 1 | Suspend pulse |
| resume_go | output | 1 | Resume pulse |
| reset_go | output | 1 | Reset pulse |
| mode | output | 3 | Current mode code |
| id_word | output | DATA_W | Identification word in auto-select |

## Verification
The bench targets the byte-mode key shift. A decoder that compared only the word-mode keys would issue a program when 8-bit writes carry 16-bit keys, and would miss the real 8-bit sequence. It checks that upper address and data bits are ignored, and that a prefix broken at its second write leaves no pending program. It also covers the restricted command sets. Under lock, during a running erase, inside bypass and under the error flag, a lax decoder would leak a program pulse or lose the bypass mode after an error reset. It also checks the suspend corner: a program while suspended must stay suspended, and a reset while suspended must not pulse.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    MD_READ   = 3'd0,
    MD_IDENT  = 3'd1,
    MD_BYPASS = 3'd2,
    MD_PROG   = 3'd3,
    MD_ESETUP = 3'd4,
    MD_SUSP   = 3'd5,
    MD_ERR    = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E0, SQ_E1, SQ_E2, SQ_BPROG, SQ_BEXIT
  } seq_e;

  typedef enum logic [1:0] {BS_READ, BS_IDENT, BS_BYPASS} base_e;

  localparam logic [7:0] OP_KEY1   = 8'hAA;
  localparam logic [7:0] OP_KEY2   = 8'h55;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_BYPASS = 8'h20;
  localparam logic [7:0] OP_ESETUP = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_BLOCK  = 8'h30;
  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_BEXIT  = 8'h00;
endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
  parameter int MATCH_W = 11
) (
  input  logic               byte_mode,
  input  logic [MATCH_W:0]   addr,
  input  logic [7:0]         data,
  output logic               hit_first,
  output logic               hit_second,
  output logic               at_cmd
);
  import fcd_pkg::*;
  localparam logic [MATCH_W-1:0] KEY_A = MATCH_W'('h555);
  localparam logic [MATCH_W-1:0] KEY_B = MATCH_W'('h2AA);
  localparam logic [MATCH_W:0]   WORD_A = {1'b0, KEY_A};
  localparam logic [MATCH_W:0]   WORD_B = {1'b0, KEY_B};
  localparam logic [MATCH_W:0]   BYTE_A = {KEY_A, 1'b0};
  localparam logic [MATCH_W:0]   BYTE_B = {KEY_B, 1'b1};

  logic [MATCH_W:0] key;
  logic [MATCH_W:0] cmp_a;
  logic [MATCH_W:0] cmp_b;

  always_comb begin
    if (byte_mode) begin
      key   = addr;
      cmp_a = BYTE_A;
      cmp_b = BYTE_B;
    end else begin
      key   = {1'b0, addr[MATCH_W-1:0]};
      cmp_a = WORD_A;
      cmp_b = WORD_B;
    end
  end

  assign at_cmd     = (key == cmp_a);
  assign hit_first  = at_cmd && (data == OP_KEY1);
  assign hit_second = (key == cmp_b) && (data == OP_KEY2);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_first,
  input  logic              hit_second,
  input  logic              at_cmd,
  input  logic              ctl_lock,
  input  logic              ctl_erase_run,
  input  logic              ctl_add_open,
  input  logic              ctl_error,
  output logic              prog_go,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_go,
  output logic              blk_add_go,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              suspend_go,
  output logic              resume_go,
  output logic              reset_go,
  output fcd_pkg::mode_e    mode
);
  import fcd_pkg::*;

  seq_e  seq;
  base_e base;
  logic  susp;
  logic [7:0] op;
  assign op = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= SQ_IDLE; base <= BS_READ; susp <= 1'b0;
      prog_go <= 1'b0; chip_erase_go <= 1'b0; blk_add_go <= 1'b0;
      suspend_go <= 1'b0; resume_go <= 1'b0; reset_go <= 1'b0;
      prog_addr <= '0; prog_data <= '0; blk_addr <= '0;
    end else begin
      prog_go <= 1'b0; chip_erase_go <= 1'b0; blk_add_go <= 1'b0;
      suspend_go <= 1'b0; resume_go <= 1'b0; reset_go <= 1'b0;
      if (wr_valid && !ctl_lock) begin
        if (ctl_error) begin
          if (op == OP_RESET && (seq == SQ_IDLE || seq == SQ_U2)) begin
            reset_go <= 1'b1;
            seq <= SQ_IDLE;
            if (base != BS_BYPASS) base <= BS_READ;
          end else if (seq == SQ_IDLE && hit_first) seq <= SQ_U1;
          else if (seq == SQ_U1 && hit_second) seq <= SQ_U2;
          else seq <= SQ_IDLE;
        end else if (base == BS_BYPASS) begin
          seq <= SQ_IDLE;
          case (seq)
            SQ_BPROG: begin
              prog_go <= 1'b1; prog_addr <= wr_addr; prog_data <= wr_data;
            end
            SQ_BEXIT: if (op == OP_BEXIT) base <= BS_READ;
            default: begin
              if (op == OP_PROG) seq <= SQ_BPROG;
              else if (op == OP_IDENT) seq <= SQ_BEXIT;
            end
          endcase
        end else if (ctl_erase_run && !susp) begin
          seq <= SQ_IDLE;
          if (op == OP_SUSP) begin
            suspend_go <= 1'b1; susp <= 1'b1;
          end else if (op == OP_RESET) reset_go <= 1'b1;
          else if (op == OP_BLOCK && ctl_add_open) begin
            blk_add_go <= 1'b1; blk_addr <= wr_addr;
          end
        end else begin
          seq <= SQ_IDLE;
          case (seq)
            SQ_IDLE: begin
              if (op == OP_RESET) begin
                base <= BS_READ;
                if (!susp) reset_go <= 1'b1;
              end else if (hit_first) seq <= SQ_U1;
              else if (op == OP_BLOCK && susp && base == BS_READ) begin
                resume_go <= 1'b1; susp <= 1'b0;
              end else base <= BS_READ;
            end
            SQ_U1: if (hit_second) seq <= SQ_U2; else base <= BS_READ;
            SQ_U2: begin
              if (op == OP_RESET) begin
                base <= BS_READ;
                if (!susp) reset_go <= 1'b1;
              end else if (at_cmd && op == OP_IDENT) base <= BS_IDENT;
              else if (at_cmd && op == OP_PROG) seq <= SQ_PROG;
              else if (at_cmd && op == OP_BYPASS && !susp) base <= BS_BYPASS;
              else if (at_cmd && op == OP_ESETUP && !susp) seq <= SQ_E0;
              else base <= BS_READ;
            end
            SQ_PROG: begin
              prog_go <= 1'b1; prog_addr <= wr_addr; prog_data <= wr_data;
              base <= BS_READ;
            end
            SQ_E0: if (hit_first) seq <= SQ_E1; else base <= BS_READ;
            SQ_E1: if (hit_second) seq <= SQ_E2; else base <= BS_READ;
            SQ_E2: begin
              base <= BS_READ;
              if (at_cmd && op == OP_CHIP) chip_erase_go <= 1'b1;
              else if (op == OP_BLOCK) begin
                blk_add_go <= 1'b1; blk_addr <= wr_addr;
              end
            end
            default: base <= BS_READ;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (ctl_error) mode = MD_ERR;
    else if (seq == SQ_PROG || seq == SQ_BPROG) mode = MD_PROG;
    else if (seq == SQ_E0 || seq == SQ_E1 || seq == SQ_E2) mode = MD_ESETUP;
    else if (base == BS_IDENT) mode = MD_IDENT;
    else if (base == BS_BYPASS) mode = MD_BYPASS;
    else if (susp) mode = MD_SUSP;
    else mode = MD_READ;
  end

  // R11
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_lock) |-> !(prog_go || chip_erase_go || blk_add_go || suspend_go || resume_go || reset_go));
  // R12
  err_reset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_error) |-> !(prog_go || chip_erase_go || blk_add_go || suspend_go || resume_go));
  // R10
  resume_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_go && !ctl_error) |-> (mode == MD_READ));
  // R3
  prog_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> $past(wr_valid));
  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, chip_erase_go, blk_add_go, suspend_go, resume_go, reset_go}));
endmodule

// File: rtl/fcd_ident.sv
module fcd_ident #(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h0037,
  parameter logic [15:0] DEV_CODE = 16'h00A5
) (
  input  fcd_pkg::mode_e    mode,
  input  logic [1:0]        id_addr,
  input  logic              id_prot,
  output logic [DATA_W-1:0] id_word
);
  import fcd_pkg::*;
  always_comb begin
    id_word = '0;
    if (mode == MD_IDENT) begin
      case (id_addr)
        2'd0: id_word = DATA_W'(MFR_CODE);
        2'd1: id_word = DATA_W'(DEV_CODE);
        2'd2: id_word = DATA_W'(id_prot);
        default: id_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter int          MATCH_W  = 11,
  parameter logic [15:0] MFR_CODE = 16'h0037,
  parameter logic [15:0] DEV_CODE = 16'h00A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_lock,
  input  logic              ctl_erase_run,
  input  logic              ctl_add_open,
  input  logic              ctl_error,
  input  logic [1:0]        id_addr,
  input  logic              id_prot,
  output logic              prog_go,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_go,
  output logic              blk_add_go,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              suspend_go,
  output logic              resume_go,
  output logic              reset_go,
  output logic [2:0]        mode,
  output logic [DATA_W-1:0] id_word
);
  import fcd_pkg::*;
  logic  hit_first, hit_second, at_cmd;
  mode_e mode_s;

  fcd_match #(.MATCH_W(MATCH_W)) u_match (
    .byte_mode(byte_mode), .addr(wr_addr[MATCH_W:0]), .data(wr_data[7:0]),
    .hit_first(hit_first), .hit_second(hit_second), .at_cmd(at_cmd));

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_first(hit_first), .hit_second(hit_second), .at_cmd(at_cmd),
    .ctl_lock(ctl_lock), .ctl_erase_run(ctl_erase_run), .ctl_add_open(ctl_add_open),
    .ctl_error(ctl_error), .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_go(chip_erase_go), .blk_add_go(blk_add_go), .blk_addr(blk_addr),
    .suspend_go(suspend_go), .resume_go(resume_go), .reset_go(reset_go), .mode(mode_s));

  fcd_ident #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_ident (
    .mode(mode_s), .id_addr(id_addr), .id_prot(id_prot), .id_word(id_word));

  assign mode = mode_s;

  // R4
  ident_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s != MD_IDENT) |-> (id_word == '0));
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  localparam logic [15:0] MFR = 16'h0037;
  localparam logic [15:0] DEV = 16'h00A5;
  logic clk = 0, rst_n = 0, byte_mode = 0, wr_valid = 0;
  logic [16:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ctl_lock = 0, ctl_erase_run = 0, ctl_add_open = 0, ctl_error = 0;
  logic [1:0] id_addr = 0;
  logic id_prot = 0;
  logic prog_go, chip_erase_go, blk_add_go, suspend_go, resume_go, reset_go;
  logic [16:0] prog_addr, blk_addr;
  logic [15:0] prog_data, id_word;
  logic [2:0] mode;
  int checks = 0, failures = 0;
  logic [35:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  flash_cmd_decoder uut (.clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_lock(ctl_lock), .ctl_erase_run(ctl_erase_run),
    .ctl_add_open(ctl_add_open), .ctl_error(ctl_error), .id_addr(id_addr), .id_prot(id_prot),
    .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data), .chip_erase_go(chip_erase_go),
    .blk_add_go(blk_add_go), .blk_addr(blk_addr), .suspend_go(suspend_go), .resume_go(resume_go),
    .reset_go(reset_go), .mode(mode), .id_word(id_word));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic expect_ev(input string tag, input logic [2:0] k, input logic [16:0] a, input logic [15:0] d);
    expq.push_back({k, a, d});
    tagq.push_back(tag);
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
    @(negedge clk);
  endtask

  task automatic prefix();
    if (byte_mode) begin wr(17'hAAA, 16'h00AA); wr(17'h555, 16'h0055); end
    else begin wr(17'h555, 16'h00AA); wr(17'h2AA, 16'h0055); end
  endtask

  // monitor: kinds 1 prog, 2 chip, 3 blk, 4 suspend, 5 resume, 6 reset
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] k;
      logic [16:0] a;
      logic [15:0] d;
      k = 0; a = 0; d = 0;
      if (prog_go) begin k = 1; a = prog_addr; d = prog_data; end
      else if (chip_erase_go) k = 2;
      else if (blk_add_go) begin k = 3; a = blk_addr; end
      else if (suspend_go) k = 4;
      else if (resume_go) k = 5;
      else if (reset_go) k = 6;
      if (k != 0) begin
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL unexpected pulse got=%h exp=none (R7 R9 R11 R12 R13)", {k, a, d});
        end else begin
          logic [35:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e !== {k, a, d}) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", t, {k, a, d}, e);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 pulses", 32'({prog_go, chip_erase_go, blk_add_go, suspend_go, resume_go, reset_go}), 0);

    // R8 single reset
    expect_ev("R8 single reset", 6, 0, 0);
    wr(17'h01234, 16'h00F0);
    chk("R8 mode", 32'(mode), 0);

    // R3 program, word mode
    prefix(); wr(17'h555, 16'h00A0);
    chk("R3 pending", 32'(mode), 3);
    expect_ev("R3 program", 1, 17'h1F0F0, 16'hBEEF);
    wr(17'h1F0F0, 16'hBEEF);
    chk("R3 back to read", 32'(mode), 0);

    // R2 upper bits ignored
    wr(17'h1F555, 16'hFFAA); wr(17'h0AAAA, 16'h1255); wr(17'h1D555, 16'h77A0);
    chk("R2 upper bits ignored", 32'(mode), 3);
    expect_ev("R2 program after masked prefix", 1, 17'h00010, 16'h1234);
    wr(17'h00010, 16'h1234);

    // R2 byte mode: word keys rejected, byte keys accepted
    byte_mode = 1;
    wr(17'h555, 16'h00AA); wr(17'h2AA, 16'h0055); wr(17'h555, 16'h00A0);
    chk("R2 word keys in byte mode", 32'(mode), 0);
    wr(17'h00020, 16'h0011);
    prefix(); wr(17'hAAA, 16'h00A0);
    chk("R2 byte keys", 32'(mode), 3);
    expect_ev("R2 byte program", 1, 17'h00021, 16'h00C3);
    wr(17'h00021, 16'h00C3);
    byte_mode = 0;

    // R4 auto-select
    prefix(); wr(17'h555, 16'h0090);
    chk("R4 mode", 32'(mode), 1);
    id_addr = 0; #1 chk("R4 mfr", 32'(id_word), 32'(MFR));
    id_addr = 1; #1 chk("R4 dev", 32'(id_word), 32'(DEV));
    id_addr = 2; id_prot = 1; #1 chk("R4 prot", 32'(id_word), 1);
    id_prot = 0; #1 chk("R4 unprot", 32'(id_word), 0);
    id_addr = 3; #1 chk("R4 other", 32'(id_word), 0);
    id_addr = 0;
    wr(17'h00000, 16'h0000);
    chk("R7 leave ident", 32'(mode), 0);
    chk("R4 idle word", 32'(id_word), 0);

    // R7 broken prefix
    wr(17'h555, 16'h00AA); wr(17'h2AB, 16'h0055);
    chk("R7 broken", 32'(mode), 0);
    wr(17'h555, 16'h00A0);
    chk("R7 no pending", 32'(mode), 0);

    // R8 prefixed reset
    expect_ev("R8 prefixed reset", 6, 0, 0);
    prefix(); wr(17'h00000, 16'h00F0);

    // R5 chip erase and block erase
    prefix(); wr(17'h555, 16'h0080);
    chk("R5 setup", 32'(mode), 4);
    prefix();
    expect_ev("R5 chip erase", 2, 0, 0);
    wr(17'h555, 16'h0010);
    chk("R5 chip mode", 32'(mode), 0);
    prefix(); wr(17'h555, 16'h0080); prefix();
    expect_ev("R5 block erase", 3, 17'h12345, 0);
    wr(17'h12345, 16'h0030);

    // R6 extra block, R13 restriction
    ctl_erase_run = 1; ctl_add_open = 1;
    expect_ev("R6 add block", 3, 17'h08000, 0);
    wr(17'h08000, 16'h0030);
    prefix(); wr(17'h555, 16'h00A0); wr(17'h00040, 16'h0001);
    chk("R13 ignored", 32'(mode), 0);
    ctl_add_open = 0;

    // R10 suspend / resume
    expect_ev("R10 suspend", 4, 0, 0);
    wr(17'h00000, 16'h00B0);
    chk("R10 susp mode", 32'(mode), 5);
    prefix(); wr(17'h555, 16'h00A0);
    expect_ev("R10 program in suspend", 1, 17'h00050, 16'h0F0F);
    wr(17'h00050, 16'h0F0F);
    chk("R10 stays suspended", 32'(mode), 5);
    wr(17'h00000, 16'h00F0);
    chk("R10 reset in suspend", 32'(mode), 5);
    expect_ev("R10 resume", 5, 0, 0);
    wr(17'h00000, 16'h0030);
    chk("R10 resumed", 32'(mode), 0);
    ctl_erase_run = 0;
    wr(17'h00000, 16'h00B0);
    chk("R10 no suspend idle", 32'(mode), 0);

    // R11 lock
    ctl_lock = 1;
    prefix(); wr(17'h555, 16'h00A0); wr(17'h00060, 16'h0002);
    chk("R11 locked", 32'(mode), 0);
    ctl_lock = 0;

    // R9 bypass
    prefix(); wr(17'h555, 16'h0020);
    chk("R9 bypass", 32'(mode), 2);
    wr(17'h00000, 16'h00A0);
    chk("R9 pending", 32'(mode), 3);
    expect_ev("R9 bypass program", 1, 17'h00100, 16'h5A5A);
    wr(17'h00100, 16'h5A5A);
    chk("R9 back to bypass", 32'(mode), 2);
    wr(17'h00000, 16'h00F0);
    chk("R9 ignored", 32'(mode), 2);

    // R12 error in bypass
    ctl_error = 1;
    @(negedge clk);
    chk("R12 err mode", 32'(mode), 6);
    wr(17'h00000, 16'h00A0); wr(17'h00200, 16'h0003);
    expect_ev("R12 reset in error", 6, 0, 0);
    wr(17'h00000, 16'h00F0);
    ctl_error = 0;
    @(negedge clk);
    chk("R12 keeps bypass", 32'(mode), 2);
    wr(17'h00000, 16'h0090); wr(17'h00000, 16'h0000);
    chk("R9 exit", 32'(mode), 0);
    ctl_error = 1;
    expect_ev("R12 prefixed reset", 6, 0, 0);
    prefix(); wr(17'h00000, 16'h00F0);
    ctl_error = 0;
    @(negedge clk);
    chk("R12 read after error", 32'(mode), 0);

    repeat (3) @(negedge clk);
    chk("R7 all expected pulses seen", 32'(expq.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule